// File: doc/BRIEF.md
# Packed Signed 16-bit Multiply / Multiply-Add Pipeline

This block takes two 64-bit source words, splits each into four signed 16-bit lanes, and forms the four lane-wise 16x16 products. Depending on the operation code it returns either the lower halves of the products, the upper halves of the products, or two 32-bit sums. Each sum adds a pair of neighbouring products. The multiply-add form is the building block of a dot product. Two such results, reduced afterwards with ordinary packed adds, cover eight element pairs.

Work is issued by pulsing `start` for one cycle with the operands and the operation code valid in that cycle. The result is registered through two stages. `done` pulses for one cycle, two cycles after the matching `start`. A new operation may be issued on every cycle, and results leave the pipeline in issue order. Between `done` pulses the result output holds the last value produced.

Top module: `pmac_unit`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `done` becomes 0 and `result` becomes 0 on that edge.
- R2: With op code 2'b00, result bits [16i+15:16i] equal the low 16 bits of the signed product of lane i of `src_a` and lane i of `src_b`, where lane i is bits [16i+15:16i].
- R3: With op code 2'b01, result bits [16i+15:16i] equal the upper 16 bits of the 32-bit signed two's-complement product of lane i of each operand.
- R4: With op code 2'b10, result[31:0] equals product0 + product1 and result[63:32] equals product2 + product3, each sum taken modulo 2^32.
- R5: With op code 2'b10 and every lane of both operands equal to 16'h8000, each 32-bit half of the result is 32'h80000000. No other indication is produced.
- R6: `done` is 1 exactly in the cycle two clock edges after a cycle in which `start` was sampled 1, and it is 0 otherwise.
- R7: With `start` held high on consecutive cycles, every operation produces its own result, in issue order, one per cycle.
- R8: Op code 2'b11 is reserved and produces a result of all zeros, with the usual `done` pulse.
- R9: Changes on `src_a`, `src_b` and `op` while `start` is 0 leave `result` unchanged and `done` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Issue strobe for the operands and op code of this cycle |
| op | input | 2 | 00 low halves, 01 high halves, 10 pairwise multiply-add, 11 reserved |
| src_a | input | 64 | First operand, four signed 16-bit lanes |
| src_b | input | 64 | Second operand, four signed 16-bit lanes |
| result | output | 64 | Registered result of the latest completed operation |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest situation to reach from the ports is a full pipeline in which every stage holds a different op code. It shows whether the op code travels with its own products or is taken from a neighbouring operation. The stimulus issues a run of operations on consecutive cycles and rotates through all four codes, with operands that differ from one operation to the next. Each result is then compared against the operation issued two cycles earlier. The wrap case of the multiply-add, with all lanes at the most negative value, is issued on its own, and again inside the back-to-back run.

// File: rtl/pmac_pkg.sv
// Shared definitions for the packed multiply unit.
// Assumes the op code is two bits wide and fixed by the requirements.
package pmac_pkg;
    typedef enum logic [1:0] {
        OP_MUL_LO = 2'b00,
        OP_MUL_HI = 2'b01,
        OP_MADD   = 2'b10,
        OP_RSVD   = 2'b11
    } pmac_op_e;
endpackage

// File: rtl/pmac_lane_mult.sv
// One lane multiplier: full-width signed product of two W-bit lanes.
// Purely combinational; the caller registers the product.
module pmac_lane_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0]   lane_a,
    input  logic [W-1:0]   lane_b,
    output logic [2*W-1:0] prod
);
    // Signed two's-complement multiply, full product kept.
    always_comb begin
        prod = $signed(lane_a) * $signed(lane_b);
    end
endmodule

// File: rtl/pmac_prod_stage.sv
// First pipeline stage: holds the lane products, op code and a valid flag.
// Assumes products arrive already computed for the current cycle.
module pmac_prod_stage
    import pmac_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PROD_W = 32,
    localparam int VEC_W = LANES * PROD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  pmac_op_e         in_op,
    input  logic [VEC_W-1:0] in_prod,
    output logic             q_valid,
    output pmac_op_e         q_op,
    output logic [VEC_W-1:0] q_prod
);
    // Capture products and op on issue; valid follows start every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_op    <= OP_MUL_LO;
            q_prod  <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q_op   <= in_op;
                q_prod <= in_prod;
            end
        end
    end
endmodule

// File: rtl/pmac_combine.sv
// Second pipeline stage: picks low or high product halves, or sums
// neighbouring products, then registers the result and the done pulse.
// Assumes LANES is even; the result keeps its value while no valid arrives.
module pmac_combine
    import pmac_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    localparam int PROD_W = 2 * LANE_W,
    localparam int VEC_W  = LANES * PROD_W,
    localparam int DATA_W = LANES * LANE_W,
    localparam int PAIRS  = LANES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  pmac_op_e          s_op,
    input  logic [VEC_W-1:0]  s_prod,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    logic [DATA_W-1:0] lo_vec;
    logic [DATA_W-1:0] hi_vec;
    logic [DATA_W-1:0] madd_vec;
    logic [DATA_W-1:0] next_res;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_half
            // Split each product into its two halves.
            assign lo_vec[gi*LANE_W +: LANE_W] = s_prod[gi*PROD_W +: LANE_W];
            assign hi_vec[gi*LANE_W +: LANE_W] = s_prod[gi*PROD_W + LANE_W +: LANE_W];
        end
        for (gi = 0; gi < PAIRS; gi++) begin : g_pair
            // Wrapping sum of two neighbouring products.
            assign madd_vec[gi*PROD_W +: PROD_W] =
                s_prod[(2*gi)*PROD_W +: PROD_W] + s_prod[(2*gi+1)*PROD_W +: PROD_W];
        end
    endgenerate

    // Select the output form from the op code carried with the products.
    always_comb begin
        case (s_op)
            OP_MUL_LO: next_res = lo_vec;
            OP_MUL_HI: next_res = hi_vec;
            OP_MADD:   next_res = madd_vec;
            default:   next_res = '0;
        endcase
    end

    // Register the result on valid and pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= s_valid;
            if (s_valid) begin
                result <= next_res;
            end
        end
    end
endmodule

// File: rtl/pmac_unit.sv
// Top of the packed multiply / multiply-add pipeline.
// Splits the operands into lanes, multiplies per lane, and passes the
// products through two register stages. Accepts one issue per cycle.
module pmac_unit
    import pmac_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    localparam int PROD_W = 2 * LANE_W,
    localparam int VEC_W  = LANES * PROD_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    logic [VEC_W-1:0] prod_raw;
    logic [VEC_W-1:0] prod_q;
    logic             valid_q;
    pmac_op_e         op_q;
    pmac_op_e         op_in;

    assign op_in = pmac_op_e'(op);

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane
            pmac_lane_mult #(.W(LANE_W)) u_mult (
                .lane_a (src_a[gl*LANE_W +: LANE_W]),
                .lane_b (src_b[gl*LANE_W +: LANE_W]),
                .prod   (prod_raw[gl*PROD_W +: PROD_W])
            );
        end
    endgenerate

    pmac_prod_stage #(.LANES(LANES), .PROD_W(PROD_W)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (start),
        .in_op    (op_in),
        .in_prod  (prod_raw),
        .q_valid  (valid_q),
        .q_op     (op_q),
        .q_prod   (prod_q)
    );

    pmac_combine #(.LANES(LANES), .LANE_W(LANE_W)) u_stage2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (valid_q),
        .s_op    (op_q),
        .s_prod  (prod_q),
        .result  (result),
        .done    (done)
    );
endmodule

// File: rtl/pmac_unit_chk.sv
// Property checker for pmac_unit, attached with bind below.
// Observes only the ports of the top module.
module pmac_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] result,
    input logic              done
);
    localparam logic [DATA_W-1:0] ALL_MIN = {(DATA_W/16){16'h8000}};
    localparam logic [DATA_W-1:0] WRAP_RES = {(DATA_W/32){32'h80000000}};

    // R1: reset clears the outputs.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (done == 1'b0 && result == '0));

    // R6: every issue produces done two edges later.
    a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 done);

    // R6: no done without a matching issue.
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2));

    // R5: all-minimum multiply-add wraps to the most negative sum.
    a_r5_min_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op, 2) == 2'b10 && $past(src_a, 2) == ALL_MIN
              && $past(src_b, 2) == ALL_MIN) |-> result == WRAP_RES);

    // R8: reserved op code yields zeros.
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(op, 2) == 2'b11) |-> result == '0);

    // R9: the result holds between done pulses.
    a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> $stable(result));
endmodule

bind pmac_unit pmac_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .src_a  (src_a),
    .src_b  (src_b),
    .result (result),
    .done   (done)
);

// File: tb/pmac_unit_bench.sv
// Directed bench for pmac_unit: one task per scenario, each checking itself.
module pmac_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] result;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    pmac_unit u_pmac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .result(result), .done(done)
    );

    // Reference built from the requirement text.
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] code);
        logic signed [31:0] p [4];
        logic [63:0] r;
        for (int i = 0; i < 4; i++)
            p[i] = 32'(signed'(a[16*i +: 16])) * 32'(signed'(b[16*i +: 16]));
        r = '0;
        case (code)
            2'b00: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
            2'b01: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
            2'b10: begin
                r[31:0]  = p[0] + p[1];
                r[63:32] = p[2] + p[3];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One isolated issue, with done checked on every cycle around it.
    task automatic single_op(input string tag, input logic [1:0] code,
                             input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        src_a = a; src_b = b; op = code; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R6 done early"}, {63'd0, done}, 64'd0);
        @(negedge clk);
        check({tag, " R6 done"}, {63'd0, done}, 64'd1);
        check(tag, result, model(a, b, code));
        @(negedge clk);
        check({tag, " R6 done single"}, {63'd0, done}, 64'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 result", result, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic test_low();
        single_op("R2 mixed", 2'b00, 64'h0003_FFFE_7FFF_1234, 64'h0005_0007_0002_0010);
        single_op("R2 negatives", 2'b00, 64'h8000_FFFF_C000_0101, 64'h8000_FFFF_0004_FF01);
    endtask

    task automatic test_high();
        single_op("R3 mixed", 2'b01, 64'h7FFF_8000_FFFF_1234, 64'h7FFF_7FFF_0001_5678);
        single_op("R3 signs", 2'b01, 64'hC000_4000_8001_0100, 64'h4000_C000_8001_FF00);
    endtask

    task automatic test_madd();
        single_op("R4 small", 2'b10, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005);
        single_op("R4 signs", 2'b10, 64'h7FFF_8000_FFFF_1234, 64'h7FFF_7FFF_0003_FFFE);
    endtask

    task automatic test_wrap();
        single_op("R5 wrap", 2'b10, {4{16'h8000}}, {4{16'h8000}});
        check("R5 wrap value", result, {2{32'h80000000}});
    endtask

    task automatic test_reserved();
        single_op("R8 reserved", 2'b11, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    endtask

    task automatic test_hold();
        logic [63:0] held;
        single_op("R9 setup", 2'b10, 64'h0010_0020_0030_0040, 64'h0002_0003_0004_0005);
        held = result;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            src_a = 64'hDEAD_BEEF_0000_1111 ^ 64'(k); src_b = ~src_a; op = 2'(k);
            @(negedge clk);
            check("R9 done idle", {63'd0, done}, 64'd0);
            check("R9 result held", result, held);
        end
    endtask

    task automatic test_back_to_back();
        logic [63:0] ea [8];
        logic [63:0] eb [8];
        logic [1:0]  eo [8];
        for (int i = 0; i < 8; i++) begin
            ea[i] = (i == 5) ? {4{16'h8000}} : 64'h1357_9BDF_2468_ACE0 + 64'h0101_0203_0304_0405 * 64'(i);
            eb[i] = (i == 5) ? {4{16'h8000}} : 64'hF00D_0123_8001_7FFE - 64'h0011_0022_0033_0044 * 64'(i);
            eo[i] = (i == 5) ? 2'b10 : 2'(i);
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R7 done", {63'd0, done}, 64'd1);
                check("R7 in order", result, model(ea[i-2], eb[i-2], eo[i-2]));
            end
            if (i < 8) begin
                src_a = ea[i]; src_b = eb[i]; op = eo[i]; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        @(negedge clk);
        check("R7 drained", {63'd0, done}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        test_reset();
        test_low();
        test_high();
        test_madd();
        test_wrap();
        test_reserved();
        test_hold();
        test_back_to_back();
        test_reset();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule